// File: doc/BRIEF.md
# LAPS Frame Receive Decapsulator

This block sits on the receive side of an Ethernet-over-SDH link. It takes a scrambled octet stream that carries LAPS-framed MAC frames and returns the MAC frames as a byte stream marked with start, end and error flags. Each accepted octet is first passed through a self-synchronous x^43+1 descrambler. The plain octets then drive a frame state machine. The state machine finds frame boundaries on the 0x7E flag, drops rate-adaptation fill pairs and decodes escape pairs. It compares the four header octets with configured values and checks the CRC-32 frame check sequence.

The four header octets and the four check octets never reach the output. A five-deep hold pipeline delays the data. When the closing flag arrives, the octet that leaves the pipeline is the last MAC byte, and it carries the end marker and the verdict. Two saturating counters record frames that were aborted and frames that were complete but bad.

The state machine has four states:
- ST_HUNT: after reset, waiting for the first flag.
- ST_FRAME: inside a frame or between flags.
- ST_ESC: a 0x7D has arrived.
- ST_DROP: the frame was aborted; waiting for the next flag.

Transitions:
- hunt-open: ST_HUNT to ST_FRAME on a flag.
- flag-close/reopen: ST_FRAME to ST_FRAME on a flag.
- escape-enter: ST_FRAME to ST_ESC on 0x7D.
- escape-decode: ST_ESC to ST_FRAME on 0x5E, 0x5D or 0xDD.
- escape-abort-reopen: ST_ESC to ST_FRAME on a flag.
- escape-abort-drop: ST_ESC to ST_DROP on any other octet.
- drop-reopen: ST_DROP to ST_FRAME on a flag.

Top module: `laps_rx_decap`

## Requirements
- R1: Descrambling. Each accepted input byte is descrambled MSB first as plain bit = received bit XOR the received bit 43 bit-times earlier. The history register is zero after reset and only advances on accepted bytes.
- R2: Before the first 0x7E after reset, all octets are ignored. Consecutive flags with no octets between them produce no output and change no counter.
- R3: Inside a frame, the pair 0x7D 0xDD is removed and contributes neither data nor CRC input.
- R4: Inside a frame, 0x7D 0x5E yields data 0x7E and 0x7D 0x5D yields data 0x7D.
- R5: The first four destuffed octets are compared in order with cfg_addr, cfg_ctrl, cfg_sapi_hi and cfg_sapi_lo. Any mismatch sets out_err on the frame's end byte and increments cnt_bad by one.
- R6: The CRC-32 is computed reflected (polynomial 0xEDB88320, start value 0xFFFFFFFF) over all destuffed octets, including the four received check octets. A frame whose result differs from 0xDEBB20E3 ends with out_err and increments cnt_bad.
- R7: Only the octets between the header and the last four octets are output. out_sop marks the first of them and out_eop the last, and out_err is 0 on a good frame.
- R8: A 0x7D followed by any octet other than 0x5E, 0x5D or 0xDD aborts the frame and increments cnt_abort. If output had started, the frame ends with out_eop and out_err. Octets are then discarded until a flag, except when the offending octet is itself a flag, which opens the next frame at once.
- R9: A frame closed with fewer than 72 destuffed octets ends with out_err and increments cnt_abort, not cnt_bad.
- R10: A single flag between two frames closes the first frame and opens the second.
- R11: During and right after reset, out_valid, out_sop, out_eop and out_err are 0 and both counters are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | in_byte holds a stream octet this cycle |
| in_byte | input | 8 | Scrambled stream octet |
| cfg_addr | input | 8 | Expected address octet (usually 0x04) |
| cfg_ctrl | input | 8 | Expected control octet (usually 0x03) |
| cfg_sapi_hi | input | 8 | Expected first SAPI octet (usually 0xFE) |
| cfg_sapi_lo | input | 8 | Expected second SAPI octet (usually 0x01) |
| out_valid | output | 1 | out_data holds a MAC byte |
| out_data | output | 8 | MAC byte |
| out_sop | output | 1 | First byte of a MAC frame |
| out_eop | output | 1 | Last byte of a MAC frame |
| out_err | output | 1 | Frame is bad; valid only with out_eop |
| cnt_abort | output | CNT_W | Saturating count of aborted or short frames |
| cnt_bad | output | CNT_W | Saturating count of header or CRC failures |

## Verification
The hardest cases to reach are the abort paths, because every octet passes through the scrambler first. The stimulus has to place a plain 0x7D followed by a bad octet, or by a flag, at an exact point in the frame. The bench builds each frame as plain octets, stuffs them, and then scrambles them with its own x^43+1 model whose history runs without a break from reset. This lets it plant an invalid escape after output has started, and a 0x7D 0x7E abort that doubles as the next opening flag.

// File: rtl/laps_rx_pkg.sv
package laps_rx_pkg;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_FRAME,
        ST_ESC,
        ST_DROP
    } rx_state_e;

    localparam logic [7:0]  FLAG_OCT    = 8'h7E;
    localparam logic [7:0]  ESC_OCT     = 8'h7D;
    localparam logic [7:0]  ESC_TO_FLAG = 8'h5E;
    localparam logic [7:0]  ESC_TO_ESC  = 8'h5D;
    localparam logic [7:0]  FILL_OCT    = 8'hDD;
    localparam logic [31:0] CRC_POLY_R  = 32'hEDB88320;
    localparam logic [31:0] CRC_RESIDUE = 32'hDEBB20E3;

    // One octet of reflected CRC-32, least significant bit first.
    function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_R;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/laps_descrambler.sv
module laps_descrambler #(
    parameter int TAP = 43
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    output logic       out_valid,
    output logic [7:0] out_byte
);
    logic [TAP-1:0] hist_q;
    logic [TAP-1:0] hist_d;
    logic [7:0]     plain;

    always_comb begin
        hist_d = hist_q;
        plain  = '0;
        for (int i = 7; i >= 0; i--) begin
            plain[i] = in_byte[i] ^ hist_d[TAP-1];
            hist_d   = {hist_d[TAP-2:0], in_byte[i]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q    <= '0;
            out_valid <= 1'b0;
            out_byte  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                hist_q   <= hist_d;
                out_byte <= plain;
            end
        end
    end
endmodule

// File: rtl/laps_crc32.sv
module laps_crc32 import laps_rx_pkg::*; (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [31:0] crc
);
    always_ff @(posedge clk) begin
        if (!rst_n)    crc <= '1;
        else if (init) crc <= '1;
        else if (en)   crc <= crc32_step(crc, din);
    end
endmodule

// File: rtl/laps_hold_pipe.sv
module laps_hold_pipe #(
    parameter int DEPTH = 5,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    output logic [W-1:0] tail
);
    logic [DEPTH-1:0][W-1:0] stg_q;
    logic [DEPTH-1:0][W-1:0] stg_d;

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_head
            assign stg_d[g] = din;
        end else begin : g_body
            assign stg_d[g] = stg_q[g-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    stg_q <= '0;
        else if (push) stg_q <= stg_d;
    end

    assign tail = stg_q[DEPTH-1];
endmodule

// File: rtl/laps_rx_decap.sv
module laps_rx_decap import laps_rx_pkg::*; #(
    parameter int SCR_TAP = 43,
    parameter int MIN_MAC = 64,
    parameter int CNT_W   = 16,
    parameter int LEN_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    input  logic [7:0]       cfg_addr,
    input  logic [7:0]       cfg_ctrl,
    input  logic [7:0]       cfg_sapi_hi,
    input  logic [7:0]       cfg_sapi_lo,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_sop,
    output logic             out_eop,
    output logic             out_err,
    output logic [CNT_W-1:0] cnt_abort,
    output logic [CNT_W-1:0] cnt_bad
);
    localparam int HDR_LEN    = 4;
    localparam int FCS_LEN    = 4;
    localparam int HOLD_DEPTH = FCS_LEN + 1;
    localparam logic [LEN_W-1:0] HDR_END   = LEN_W'(HDR_LEN);
    localparam logic [LEN_W-1:0] FIRST_OUT = LEN_W'(HDR_LEN + HOLD_DEPTH);
    localparam logic [LEN_W-1:0] MIN_OCT   = LEN_W'(HDR_LEN + MIN_MAC + FCS_LEN);

    logic        d_valid;
    logic [7:0]  d_byte;
    logic [31:0] crc;
    logic [7:0]  hold_tail;

    rx_state_e        state_q, state_d;
    logic [LEN_W-1:0] oct_cnt_q;
    logic             hdr_bad_q;

    logic       acc, do_start, do_close, do_abort;
    logic [7:0] acc_byte;
    logic [7:0] hdr_exp;
    logic       is_flag, is_esc, is_short, crc_bad, has_out;
    logic       o_valid_d, o_sop_d, o_eop_d, o_err_d;
    logic       inc_abort, inc_bad;

    laps_descrambler #(.TAP(SCR_TAP)) descr_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .out_valid(d_valid), .out_byte(d_byte)
    );

    laps_crc32 crc_i (
        .clk(clk), .rst_n(rst_n), .init(do_start), .en(acc),
        .din(acc_byte), .crc(crc)
    );

    laps_hold_pipe #(.DEPTH(HOLD_DEPTH), .W(8)) hold_i (
        .clk(clk), .rst_n(rst_n), .push(acc && (oct_cnt_q >= HDR_END)),
        .din(acc_byte), .tail(hold_tail)
    );

    assign is_flag  = (d_byte == FLAG_OCT);
    assign is_esc   = (d_byte == ESC_OCT);
    assign is_short = (oct_cnt_q < MIN_OCT);
    assign crc_bad  = (crc != CRC_RESIDUE);
    assign has_out  = (oct_cnt_q >= FIRST_OUT);

    // Next-state and frame-event decode.
    always_comb begin
        state_d  = state_q;
        acc      = 1'b0;
        acc_byte = d_byte;
        do_start = 1'b0;
        do_close = 1'b0;
        do_abort = 1'b0;
        if (d_valid) begin
            unique case (state_q)
                ST_HUNT: begin
                    if (is_flag) begin
                        do_start = 1'b1;
                        state_d  = ST_FRAME;
                    end
                end
                ST_FRAME: begin
                    if (is_flag) begin
                        do_close = (oct_cnt_q != '0);
                        do_start = 1'b1;
                    end else if (is_esc) begin
                        state_d = ST_ESC;
                    end else begin
                        acc = 1'b1;
                    end
                end
                ST_ESC: begin
                    state_d = ST_FRAME;
                    if (d_byte == ESC_TO_FLAG) begin
                        acc      = 1'b1;
                        acc_byte = FLAG_OCT;
                    end else if (d_byte == ESC_TO_ESC) begin
                        acc      = 1'b1;
                        acc_byte = ESC_OCT;
                    end else if (d_byte == FILL_OCT) begin
                        acc = 1'b0;
                    end else if (is_flag) begin
                        do_abort = 1'b1;
                        do_start = 1'b1;
                    end else begin
                        do_abort = 1'b1;
                        state_d  = ST_DROP;
                    end
                end
                ST_DROP: begin
                    if (is_flag) begin
                        do_start = 1'b1;
                        state_d  = ST_FRAME;
                    end
                end
                default: state_d = ST_HUNT;
            endcase
        end
    end

    always_comb begin
        unique case (oct_cnt_q[1:0])
            2'd0:    hdr_exp = cfg_addr;
            2'd1:    hdr_exp = cfg_ctrl;
            2'd2:    hdr_exp = cfg_sapi_hi;
            default: hdr_exp = cfg_sapi_lo;
        endcase
    end

    // Output and counter decisions.
    always_comb begin
        o_valid_d = 1'b0;
        o_sop_d   = 1'b0;
        o_eop_d   = 1'b0;
        o_err_d   = 1'b0;
        inc_abort = 1'b0;
        inc_bad   = 1'b0;
        if (acc && has_out) begin
            o_valid_d = 1'b1;
            o_sop_d   = (oct_cnt_q == FIRST_OUT);
        end
        if ((do_close || do_abort) && has_out) begin
            o_valid_d = 1'b1;
            o_sop_d   = (oct_cnt_q == FIRST_OUT);
            o_eop_d   = 1'b1;
            o_err_d   = do_abort | is_short | hdr_bad_q | crc_bad;
        end
        if (do_abort) begin
            inc_abort = 1'b1;
        end else if (do_close) begin
            inc_abort = is_short;
            inc_bad   = !is_short && (hdr_bad_q || crc_bad);
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_d;
    end

    // Frame bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oct_cnt_q <= '0;
            hdr_bad_q <= 1'b0;
        end else if (do_start) begin
            oct_cnt_q <= '0;
            hdr_bad_q <= 1'b0;
        end else if (acc) begin
            if (oct_cnt_q != '1) oct_cnt_q <= oct_cnt_q + 1'b1;
            if ((oct_cnt_q < HDR_END) && (acc_byte != hdr_exp)) hdr_bad_q <= 1'b1;
        end
    end

    // Registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_sop   <= 1'b0;
            out_eop   <= 1'b0;
            out_err   <= 1'b0;
            cnt_abort <= '0;
            cnt_bad   <= '0;
        end else begin
            out_valid <= o_valid_d;
            out_data  <= hold_tail;
            out_sop   <= o_sop_d;
            out_eop   <= o_eop_d;
            out_err   <= o_err_d;
            if (inc_abort && (cnt_abort != '1)) cnt_abort <= cnt_abort + 1'b1;
            if (inc_bad && (cnt_bad != '1))     cnt_bad   <= cnt_bad + 1'b1;
        end
    end
endmodule

// File: rtl/laps_rx_decap_chk.sv
module laps_rx_decap_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             out_valid,
    input logic             out_sop,
    input logic             out_eop,
    input logic             out_err,
    input logic [CNT_W-1:0] cnt_abort,
    input logic [CNT_W-1:0] cnt_bad
);
    logic open_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                   open_q <= 1'b0;
        else if (out_valid && out_eop) open_q <= 1'b0;
        else if (out_valid && out_sop) open_q <= 1'b1;
    end

    p_sop_when_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sop) |-> !open_q);

    p_body_when_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_sop) |-> open_q);

    p_marks_need_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(out_sop || out_eop || out_err));

    p_err_on_eop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_err) |-> out_eop);

    p_abort_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_abort != $past(cnt_abort)) |-> (cnt_abort == $past(cnt_abort) + 1'b1));

    p_bad_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_bad != $past(cnt_bad)) |-> (cnt_bad == $past(cnt_bad) + 1'b1));
endmodule

bind laps_rx_decap laps_rx_decap_chk #(.CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_sop(out_sop),
    .out_eop(out_eop), .out_err(out_err), .cnt_abort(cnt_abort), .cnt_bad(cnt_bad)
);

// File: tb/laps_rx_decap_tb_top.sv
`timescale 1ns/1ps
module laps_rx_decap_tb_top;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        out_valid, out_sop, out_eop, out_err;
    logic [7:0]  out_data;
    logic [15:0] cnt_abort, cnt_bad;

    laps_rx_decap dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .cfg_addr(8'h04), .cfg_ctrl(8'h03), .cfg_sapi_hi(8'hFE), .cfg_sapi_lo(8'h01),
        .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop),
        .out_eop(out_eop), .out_err(out_err), .cnt_abort(cnt_abort), .cnt_bad(cnt_bad)
    );

    typedef struct packed {
        logic [15:0] len;
        logic [2:0]  hdrf;
        logic        fcsf;
        logic        fill;
        logic        eerr;
        logic        eab;
        logic        ebad;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{16'd64,  3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{16'd100, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{16'd64,  3'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
        '{16'd70,  3'd4, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
        '{16'd80,  3'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
        '{16'd40,  3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
        '{16'd300, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{16'd63,  3'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}
    };

    int n_chk = 0;
    int n_fail = 0;
    logic [42:0] scr_h = '0;
    logic [7:0] txq[$];
    logic [7:0] expq[$];
    logic [7:0] cap_d[$];
    logic       cap_sop[$];
    logic       cap_eop[$];
    logic       cap_err[$];

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            cap_d.push_back(out_data);
            cap_sop.push_back(out_sop);
            cap_eop.push_back(out_eop);
            cap_err.push_back(out_err);
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] d);
        logic [7:0] s;
        for (int i = 7; i >= 0; i--) begin
            s[i]  = d[i] ^ scr_h[42];
            scr_h = {scr_h[41:0], s[i]};
        end
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = s;
    endtask

    task automatic send_txq();
        while (txq.size() > 0) send_byte(txq.pop_front());
        @(negedge clk);
        in_valid = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic clear_caps();
        cap_d.delete(); cap_sop.delete(); cap_eop.delete(); cap_err.delete();
        expq.delete(); txq.delete();
    endtask

    task automatic push_stuffed(input logic [7:0] b);
        if (b == 8'h7E)      begin txq.push_back(8'h7D); txq.push_back(8'h5E); end
        else if (b == 8'h7D) begin txq.push_back(8'h7D); txq.push_back(8'h5D); end
        else                 txq.push_back(b);
    endtask

    // Frame body without flags: header, payload, check octets, stuffed.
    task automatic build_frame(input int len, input int seed, input int hdrf,
                               input bit fcsf, input bit fill);
        logic [7:0]  oct[$];
        logic [31:0] c;
        logic [7:0]  p;
        oct = '{8'h04, 8'h03, 8'hFE, 8'h01};
        if (hdrf > 0) oct[hdrf-1] = oct[hdrf-1] ^ 8'h10;
        for (int i = 0; i < len; i++) begin
            p = 8'(seed + i * 7);
            if (i == 5) p = 8'h7E;
            if (i == 6) p = 8'h7D;
            oct.push_back(p);
            expq.push_back(p);
        end
        c = 32'hFFFFFFFF;
        foreach (oct[k]) begin
            for (int b = 0; b < 8; b++) begin
                if (c[0] ^ oct[k][b]) c = (c >> 1) ^ 32'hEDB88320;
                else                  c = c >> 1;
            end
        end
        c = ~c;
        for (int k = 0; k < 4; k++) oct.push_back(c[8*k +: 8]);
        if (fcsf) oct[len+4] = oct[len+4] ^ 8'h01;
        foreach (oct[k]) begin
            if (fill && (k % 10 == 3)) begin txq.push_back(8'h7D); txq.push_back(8'hDD); end
            push_stuffed(oct[k]);
        end
        if (fill) begin txq.push_back(8'h7D); txq.push_back(8'hDD); end
    endtask

    // Compare captured bytes from index 'from' with the expected payload queue.
    task automatic check_data(input string tag, input int from);
        int bad = 0;
        for (int i = 0; i < expq.size(); i++)
            if ((from + i >= cap_d.size()) || (cap_d[from+i] != expq[i])) bad++;
        chk(bad == 0, tag, bad, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired (all requirements): actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int ab0, bd0, n;
        repeat (4) @(negedge clk);
        // R11: reset state
        chk(out_valid == 1'b0, "R11 out_valid in reset", int'(out_valid), 0);
        chk(!(out_sop || out_eop || out_err), "R11 marks in reset", int'(out_eop), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cnt_abort == 0 && cnt_bad == 0, "R11 counters after reset", int'(cnt_abort), 0);

        // R2: noise before the first flag, then idle flags
        clear_caps();
        txq = '{8'h11, 8'h7D, 8'h22, 8'h7D, 8'hDD, 8'h33, 8'h7E, 8'h7E, 8'h7E, 8'h7E};
        send_txq();
        chk(cap_d.size() == 0, "R2 no output from hunt and idle flags", cap_d.size(), 0);
        chk(cnt_abort == 0 && cnt_bad == 0, "R2 counters unchanged", int'(cnt_abort + cnt_bad), 0);

        // Table of frame vectors
        for (int v = 0; v < NV; v++) begin
            clear_caps();
            ab0 = cnt_abort; bd0 = cnt_bad;
            txq.push_back(8'h7E);
            build_frame(int'(VECS[v].len), 3 + 11 * v, int'(VECS[v].hdrf), VECS[v].fcsf, VECS[v].fill);
            txq.push_back(8'h7E); txq.push_back(8'h7E);
            send_txq();
            n = int'(VECS[v].len);
            chk(cap_d.size() == n, $sformatf("R7 byte count v%0d", v), cap_d.size(), n);
            check_data($sformatf("R1 R3 R4 R7 data v%0d", v), 0);
            if (cap_d.size() == n && n > 0) begin
                chk(cap_sop[0] && cap_eop[n-1], $sformatf("R7 sop/eop v%0d", v),
                    int'({cap_sop[0], cap_eop[n-1]}), 3);
                chk(cap_err[n-1] == VECS[v].eerr, $sformatf("R5 R6 R9 err flag v%0d", v),
                    int'(cap_err[n-1]), int'(VECS[v].eerr));
            end
            chk(int'(cnt_abort) - ab0 == int'(VECS[v].eab), $sformatf("R9 abort count v%0d", v),
                int'(cnt_abort) - ab0, int'(VECS[v].eab));
            chk(int'(cnt_bad) - bd0 == int'(VECS[v].ebad), $sformatf("R5 R6 bad count v%0d", v),
                int'(cnt_bad) - bd0, int'(VECS[v].ebad));
        end

        // R8: invalid escape after output started, then discard until flag
        clear_caps();
        ab0 = cnt_abort; bd0 = cnt_bad;
        txq = '{8'h7E, 8'h04, 8'h03, 8'hFE, 8'h01};
        for (int i = 0; i < 30; i++) txq.push_back(8'(8'h20 + i));
        txq.push_back(8'h7D); txq.push_back(8'h11);
        for (int i = 0; i < 4; i++) txq.push_back(8'h55);
        txq.push_back(8'h7E);
        build_frame(64, 77, 0, 1'b0, 1'b0);
        txq.push_back(8'h7E); txq.push_back(8'h7E);
        send_txq();
        chk(cap_d.size() == 90, "R8 bytes around bad escape", cap_d.size(), 90);
        if (cap_d.size() == 90) begin
            chk(cap_eop[25] && cap_err[25], "R8 abort end marked with error",
                int'({cap_eop[25], cap_err[25]}), 3);
            chk(cap_sop[26] && !cap_err[89], "R8 next frame clean", int'(cap_err[89]), 0);
        end
        check_data("R8 data after drop", 26);
        chk(int'(cnt_abort) - ab0 == 1, "R8 abort count", int'(cnt_abort) - ab0, 1);
        chk(int'(cnt_bad) == bd0, "R8 bad count unchanged", int'(cnt_bad), bd0);

        // R8 R10: escape then flag aborts and opens the next frame
        clear_caps();
        ab0 = cnt_abort;
        txq = '{8'h7E, 8'h04, 8'h03, 8'hFE, 8'h01};
        for (int i = 0; i < 16; i++) txq.push_back(8'(8'h30 + i));
        txq.push_back(8'h7D); txq.push_back(8'h7E);
        build_frame(64, 91, 0, 1'b0, 1'b1);
        txq.push_back(8'h7E);
        send_txq();
        chk(cap_d.size() == 76, "R8 R10 bytes for abort-reopen", cap_d.size(), 76);
        if (cap_d.size() == 76) begin
            chk(cap_eop[11] && cap_err[11], "R8 aborted end", int'({cap_eop[11], cap_err[11]}), 3);
            chk(cap_sop[12] && cap_eop[75] && !cap_err[75], "R10 reopened frame good",
                int'(cap_err[75]), 0);
        end
        check_data("R10 data of reopened frame", 12);
        chk(int'(cnt_abort) - ab0 == 1, "R8 abort count for flag abort", int'(cnt_abort) - ab0, 1);

        // R10: one flag shared between two frames
        clear_caps();
        ab0 = cnt_abort; bd0 = cnt_bad;
        txq.push_back(8'h7E);
        build_frame(64, 5, 0, 1'b0, 1'b0);
        txq.push_back(8'h7E);
        build_frame(80, 200, 0, 1'b0, 1'b1);
        txq.push_back(8'h7E);
        send_txq();
        chk(cap_d.size() == 144, "R10 bytes for shared flag", cap_d.size(), 144);
        if (cap_d.size() == 144)
            chk(cap_eop[63] && cap_sop[64] && !cap_err[63] && !cap_err[143],
                "R10 boundary markers", int'({cap_eop[63], cap_sop[64]}), 3);
        check_data("R10 data of both frames", 0);
        chk(int'(cnt_abort) == ab0 && int'(cnt_bad) == bd0, "R10 counters unchanged",
            int'(cnt_abort + cnt_bad), ab0 + bd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule